// File: doc/BRIEF.md
# Countdown Seconds Alarm

The block is a seconds-resolution alarm that counts down a value loaded by software. Once the count enable is set, every one-cycle pulse on the seconds tick input lowers the remaining count by one until it reaches zero. The step from one to zero raises a sticky pending flag. The flag stays set until software writes a one to it.

Two outputs carry the pending flag out of the block, each behind its own enable. The interrupt line goes to the interrupt controller. The wake request goes to the power controller. Software drives everything through a small word-wide register port. Writes happen on a write strobe, and reads are combinational on the address.

Register addresses on `regAddr`:
- 0: the remaining count.
- 1: count enable.
- 2: interrupt enable.
- 3: pending status.
- 4: wake enable.

Top module: `countdown_alarm`

## Requirements
- R1: After reset the count reads 0, the three enable bits read 0, the pending flag reads 0, and `irqOut` and `wakeOut` are low.
- R2: A write to address 0 loads the full 32-bit remaining count in the cycle of the write. A read of address 0 returns the current count.
- R3: When bit 0 of address 1 (count enable) is 1 and the count is nonzero, each cycle with `secTick` high lowers the count by exactly one. Without `secTick`, or with count enable at 0, the count holds.
- R4: The tick that takes the count from 1 to 0 sets the pending flag (bit 0 of address 3) at the same clock edge. Further ticks at a count of 0 leave the count at 0 and raise no new event.
- R5: A counter write in the same cycle as a tick takes the written value with no decrement. It raises no pending event, even when the old count was 1.
- R6: The pending flag is sticky. Writing address 3 with bit 0 = 1 clears it. Writing bit 0 = 0 leaves it unchanged.
- R7: When an expiry and a clear write of the pending flag fall in the same cycle, the pending flag ends up set.
- R8: `irqOut` is high exactly when the pending flag is set and bit 0 of address 2 (interrupt enable) is 1.
- R9: `wakeOut` is high exactly when the pending flag is set and bit 0 of address 4 (wake enable) is 1.
- R10: With the count written to 0 and all enables cleared, the unit stays idle under any ticks: count 0, pending 0, both outputs low.
- R11: For addresses 1, 2 and 4:
  - only bit 0 of a write is stored;
  - a read returns that bit in bit 0 and zeros elsewhere.

  Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| secTick | input | 1 | One-cycle pulse per second |
| irqOut | output | 1 | Alarm interrupt request |
| wakeOut | output | 1 | Alarm wake-up request |

## Verification
Every register write and every tick takes effect at the clock edge that samples it. After that edge, the new count, the pending flag and both gated outputs are already visible. A read is valid in the same cycle its address is presented.

The bench therefore applies each stimulus one time unit after a rising edge and holds it across exactly one edge. It checks results one time unit after that edge, with no extra latency allowed for any result.

Sweeps run the countdown from several load values and test every combination of pending state and output enables. The expected count and flags come from simple arithmetic on the tick number.

// File: rtl/cda_pkg.sv
package cda_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_RUN    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IRQEN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_WAKE   = 3'd4;

  typedef struct packed {
    logic load;
    logic dec;
  } dpStrobe_t;
endpackage

// File: rtl/cda_datapath.sv
module cda_datapath
  import cda_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic isZero;
  logic stepOk;

  assign isZero = (count == '0);
  // A load in the same cycle beats the tick.
  assign stepOk = strb.dec && !isZero && !strb.load;
  assign expire = stepOk && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strb.load) begin
      count <= loadVal;
    end else if (stepOk) begin
      count <= count - ONE;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(strb.load) && (count != $past(count))) |-> (count == $past(count) - ONE)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.dec) |=> $stable(count)); // R3
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
    (isZero && !strb.load) |=> (count == '0)); // R4
endmodule

// File: rtl/cda_ctrl.sv
module cda_ctrl
  import cda_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              secTick,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output dpStrobe_t         strb,
  output logic [CNT_W-1:0]  loadVal,
  output logic              irqOut,
  output logic              wakeOut
);
  logic runEn, irqEn, wakeEn, pending;
  logic clrReq;

  assign clrReq       = regWe && (regAddr == ADR_STATUS) && regWdata[0];
  assign strb.load    = regWe && (regAddr == ADR_COUNT);
  assign strb.dec     = secTick && runEn;
  assign loadVal      = regWdata[CNT_W-1:0];
  assign irqOut       = pending && irqEn;
  assign wakeOut      = pending && wakeEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      runEn  <= 1'b0;
      irqEn  <= 1'b0;
      wakeEn <= 1'b0;
    end else if (regWe) begin
      if (regAddr == ADR_RUN)   runEn  <= regWdata[0];
      if (regAddr == ADR_IRQEN) irqEn  <= regWdata[0];
      if (regAddr == ADR_WAKE)  wakeEn <= regWdata[0];
    end
  end

  // Expiry has priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)         pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (clrReq) pending <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADR_COUNT:  regRdata = DATA_W'(count);
      ADR_RUN:    regRdata[0] = runEn;
      ADR_IRQEN:  regRdata[0] = irqEn;
      ADR_STATUS: regRdata[0] = pending;
      ADR_WAKE:   regRdata[0] = wakeEn;
      default:    regRdata = '0;
    endcase
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    expire |=> pending); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pending && !clrReq) |=> pending); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (expire && clrReq) |=> pending); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!pending && !expire) |=> !pending); // R10
endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm
  import cda_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              secTick,
  output logic              irqOut,
  output logic              wakeOut
);
  dpStrobe_t        strb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;
  logic             expire;

  cda_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .secTick(secTick),
    .count(count), .expire(expire), .strb(strb), .loadVal(loadVal),
    .irqOut(irqOut), .wakeOut(wakeOut)
  );

  cda_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .loadVal(loadVal),
    .count(count), .expire(expire)
  );

  AST_IRQ_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> ($past(expire) || $past(regWe))); // R8
endmodule

// File: tb/countdown_alarm_tb.sv
module countdown_alarm_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        secTick;
  logic        irqOut;
  logic        wakeOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  countdown_alarm u_dut (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .secTick(secTick),
    .irqOut(irqOut), .wakeOut(wakeOut)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    step();
    regWe = 1'b0;
  endtask

  task automatic tick();
    secTick = 1'b1;
    step();
    secTick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic chkReg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; regWe = 1'b0; regAddr = '0; regWdata = '0; secTick = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state
    for (int a = 0; a < 5; a++) chkReg("R1", 3'(a), 32'd0);
    chk("R1 irq", {31'd0, irqOut}, 32'd0);
    chk("R1 wake", {31'd0, wakeOut}, 32'd0);

    // R2 load and readback
    wr(3'd0, 32'hDEADBEEF);
    chkReg("R2", 3'd0, 32'hDEADBEEF);

    // R2 / R3 maximum value decrement
    wr(3'd0, 32'hFFFFFFFF);
    wr(3'd1, 32'd1);
    tick();
    chkReg("R2 max", 3'd0, 32'hFFFFFFFE);

    // R3 / R4 countdown sweep
    for (int n = 1; n <= 6; n++) begin
      wr(3'd3, 32'd1);
      wr(3'd0, 32'(n));
      for (int k = 1; k <= n; k++) begin
        tick();
        chkReg("R3 count", 3'd0, 32'(n - k));
        chkReg("R4 pend", 3'd3, (k == n) ? 32'd1 : 32'd0);
        if (k < n) begin
          step();
          chkReg("R3 no tick hold", 3'd0, 32'(n - k));
        end
      end
      wr(3'd3, 32'd1);
      tick();
      chkReg("R4 zero stays", 3'd0, 32'd0);
      chkReg("R4 no new event", 3'd3, 32'd0);
    end

    // R3 run disabled holds
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd7);
    for (int i = 0; i < 3; i++) tick();
    chkReg("R3 run off", 3'd0, 32'd7);

    // R6 sticky, write 0 ignored, write 1 clears
    wr(3'd1, 32'd1);
    wr(3'd0, 32'd1);
    tick();
    wr(3'd3, 32'd0);
    chkReg("R6 write0", 3'd3, 32'd1);
    step();
    chkReg("R6 sticky", 3'd3, 32'd1);
    wr(3'd3, 32'd1);
    chkReg("R6 clear", 3'd3, 32'd0);

    // R5 write plus tick: write wins, no event
    wr(3'd0, 32'd1);
    regWe = 1'b1; regAddr = 3'd0; regWdata = 32'd9; secTick = 1'b1;
    step();
    regWe = 1'b0; secTick = 1'b0;
    chkReg("R5 load wins", 3'd0, 32'd9);
    chkReg("R5 no pend", 3'd3, 32'd0);
    wr(3'd0, 32'd1);
    regWe = 1'b1; regAddr = 3'd0; regWdata = 32'd0; secTick = 1'b1;
    step();
    regWe = 1'b0; secTick = 1'b0;
    chkReg("R5 load zero no pend", 3'd3, 32'd0);

    // R7 set wins over clear
    wr(3'd0, 32'd1);
    regWe = 1'b1; regAddr = 3'd3; regWdata = 32'd1; secTick = 1'b1;
    step();
    regWe = 1'b0; secTick = 1'b0;
    chkReg("R7 set wins", 3'd3, 32'd1);
    chkReg("R7 count", 3'd0, 32'd0);

    // R8 / R9 output gating sweep
    for (int c = 0; c < 8; c++) begin
      logic ie, we, pe;
      ie = c[0]; we = c[1]; pe = c[2];
      wr(3'd3, 32'd1);
      wr(3'd2, {31'd0, ie});
      wr(3'd4, {31'd0, we});
      if (pe) begin
        wr(3'd0, 32'd1);
        tick();
      end
      chk("R8 irq", {31'd0, irqOut}, {31'd0, ie & pe});
      chk("R9 wake", {31'd0, wakeOut}, {31'd0, we & pe});
    end

    // R11 only bit 0 of enables stored, unused addresses read 0
    wr(3'd1, 32'hFFFFFFFE);
    chkReg("R11 run bit0", 3'd1, 32'd0);
    wr(3'd2, 32'hFFFFFFFF);
    chkReg("R11 irqen", 3'd2, 32'd1);
    wr(3'd4, 32'h00000003);
    chkReg("R11 wake", 3'd4, 32'd1);
    for (int a = 5; a < 8; a++) chkReg("R11 unused", 3'(a), 32'd0);

    // R10 idle configuration
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd4, 32'd0);
    wr(3'd3, 32'd1);
    for (int i = 0; i < 5; i++) tick();
    chkReg("R10 count", 3'd0, 32'd0);
    chkReg("R10 pend", 3'd3, 32'd0);
    chk("R10 irq", {31'd0, irqOut}, 32'd0);
    chk("R10 wake", {31'd0, wakeOut}, 32'd0);

    // R4 run enabled at zero raises nothing
    wr(3'd1, 32'd1);
    for (int i = 0; i < 3; i++) tick();
    chkReg("R4 zero run", 3'd3, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule